// File: doc/BRIEF.md
# Read-Released Latching Status and Self-Clearing Control Bank

This block holds a word of status bits that sample live hardware signals. Each bit is built as one of three kinds, set by a parameter: latch-low, latch-high or latch-on-change. When a bit sees its kind's event, it freezes its read value. It keeps that value until software reads the status word. After that read, the bit follows its live input again. The same read can capture an event that arrives at that moment, so no event is lost.

A parameter marks which bits are interrupting. A frozen interrupting bit drives the single interrupt line unless its mask bit is set.

The block also holds a small word of control bits. Software writes these bits. Each one clears itself when its completion pulse arrives, or after a fixed number of cycles, whichever comes first. Address decoding and bus timing stay outside the block: the host supplies one-cycle strobes and a select bit.

Top module: `status_latch_bank`

## Requirements
- R1: After reset, the status word reads 1 on latch-low bits and 0 on the others. The control word reads 0 and `irq` is low.
- R2: For a latch-low bit (kind code 0 in `KIND[2i+1:2i]`), a live 0 sampled at an edge makes the bit read 0 from that edge on. It keeps reading 0 through later live 1s until the bit is released.
- R3: For a latch-high bit (kind code 1), a live 1 sampled at an edge makes the bit read 1. It keeps reading 1 until the bit is released.
- R4: For a latch-on-change bit (kind code 2 or 3), a live value that differs from the bit's read value at an edge is captured. The bit then holds that value until it is released.
- R5: A status read is `rd_stb`=1 with `rd_sel`=0 at an edge. It releases every frozen bit, and each bit loads its live value at that edge. If that live value is itself an event for the bit, the bit freezes again at once. Bits that are not frozen do not hold: they follow their live value one edge late.
- R6: `irq` is the OR of all frozen bits that have a 1 in `IRQ_EN` and a 0 in `irq_mask`. It falls after a read that leaves none of those bits frozen.
- R7: A 1 in `irq_mask[i]` keeps bit i from raising `irq`. The bit still freezes and reads as usual.
- R8: `wr_stb`=1 at an edge loads `wr_data` into the control bits. With `rd_sel`=1, `rd_data` shows the control bits in its low `NC` positions and zeros above them. A write does not change any status bit.
- R9: A set control bit clears at the edge where its `done` bit is 1. If `wr_stb` is 1 at the same edge, the written value takes priority.
- R10: A control bit written to 1 and given no `done` pulse reads 1 for exactly `TIMEOUT` cycles. It then clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| live | input | NB | Live hardware status signals |
| rd_stb | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 selects the status word, 1 selects the control word |
| wr_stb | input | 1 | Write strobe for the control word |
| wr_data | input | NC | Value written into the control bits |
| irq_mask | input | NB | 1 masks that bit's interrupt |
| done | input | NC | Completion pulses, one per control bit |
| rd_data | output | NB | Selected word, combinational from state and `rd_sel` |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take `live`, `done` and the strobes to be synchronous to `clk` and stable around each rising edge. They also expect `rst_n` to be held low before the first edge, so that no property is sampled on uninitialised state. The bench changes every input on the falling edge only and releases reset at a falling edge. Strobes and `done` are driven as whole-cycle levels, never as glitches, so the edge-sampled view the checker uses matches what the stimulus does.

// File: rtl/status_latch_bank.sv
`timescale 1ns/1ps
module status_latch_bank #(
  parameter int NB = 8,
  parameter int NC = 4,
  parameter int TIMEOUT = 16,
  parameter logic [2*NB-1:0] KIND = 16'hA540,
  parameter logic [NB-1:0] IRQ_EN = 8'b1100_1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] live,
  input  logic          rd_stb,
  input  logic          rd_sel,
  input  logic          wr_stb,
  input  logic [NC-1:0] wr_data,
  input  logic [NB-1:0] irq_mask,
  input  logic [NC-1:0] done,
  output logic [NB-1:0] rd_data,
  output logic          irq
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [NB-1:0] val, lat;
  logic [NC-1:0] ctl;
  logic [CW-1:0] cnt [NC];
  logic          rel;

  assign rel = rd_stb && !rd_sel;

  for (genvar i = 0; i < NB; i++) begin : g_stat
    localparam logic [1:0] K = KIND[2*i +: 2];
    logic ev;
    assign ev = (K == 2'd0) ? ~live[i] :
                (K == 2'd1) ?  live[i] : (live[i] ^ val[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val[i] <= (K == 2'd0);
        lat[i] <= 1'b0;
      end else if (!lat[i] || rel) begin
        val[i] <= live[i];
        lat[i] <= ev;
      end
    end
  end

  for (genvar j = 0; j < NC; j++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl[j] <= 1'b0;
        cnt[j] <= '0;
      end else if (wr_stb) begin
        ctl[j] <= wr_data[j];
        cnt[j] <= '0;
      end else if (ctl[j]) begin
        if (done[j] || cnt[j] == CW'(TIMEOUT - 1)) begin
          ctl[j] <= 1'b0;
          cnt[j] <= '0;
        end else begin
          cnt[j] <= cnt[j] + 1'b1;
        end
      end
    end
  end

  assign rd_data = rd_sel ? NB'(ctl) : val;
  assign irq = |(lat & IRQ_EN & ~irq_mask);
endmodule

module status_latch_bank_chk #(
  parameter int NB = 8,
  parameter int NC = 4,
  parameter logic [2*NB-1:0] KIND = 16'hA540
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] live,
  input logic          rd_stb,
  input logic          rd_sel,
  input logic          wr_stb,
  input logic [NB-1:0] irq_mask,
  input logic [NC-1:0] done,
  input logic [NB-1:0] val,
  input logic [NB-1:0] lat,
  input logic [NC-1:0] ctl,
  input logic          irq
);
  for (genvar i = 0; i < NB; i++) begin : g_b
    localparam logic [1:0] K = KIND[2*i +: 2];
    if (K == 2'd0) begin : g_lo
      // R2
      low_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live[i] |=> !val[i]);
    end else if (K == 2'd1) begin : g_hi
      // R3
      high_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live[i] |=> val[i]);
    end else begin : g_tr
      // R4
      change_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat[i] && (live[i] != val[i])) |=> (lat[i] && val[i] == $past(live[i])));
    end
    // R5
    hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[i] && !(rd_stb && !rd_sel)) |=> $stable(val[i]));
  end

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(lat & ~irq_mask));
  // R7
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq);

  for (genvar j = 0; j < NC; j++) begin : g_c
    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done[j] && !wr_stb) |=> !ctl[j]);
    // R8
    ctl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !ctl[j]) |=> !ctl[j]);
  end
endmodule

bind status_latch_bank status_latch_bank_chk #(.NB(NB), .NC(NC), .KIND(KIND)) u_chk (.*);

// File: tb/status_latch_bank_bench.sv
`timescale 1ns/1ps
module status_latch_bank_bench;
  localparam int NB = 8, NC = 4, TO = 16;
  localparam logic [2*NB-1:0] KIND = 16'hA540;
  localparam logic [NB-1:0] IEN = 8'b1100_1010;
  localparam logic [NB-1:0] B = 8'b0000_0111;

  logic clk = 0, rst_n = 0;
  logic [NB-1:0] live = B, irq_mask = '0, rd_data;
  logic rd_stb = 0, rd_sel = 0, wr_stb = 0, irq;
  logic [NC-1:0] wr_data = '0, done = '0;

  int total = 0, bad = 0;
  logic [NB-1:0] mv, ml;
  logic [NC-1:0] mc;
  int mcnt [NC];
  logic [31:0] r = 32'h1234_5678;

  always #5 clk = ~clk;

  status_latch_bank #(.NB(NB), .NC(NC), .TIMEOUT(TO), .KIND(KIND), .IRQ_EN(IEN))
    u_status_latch_bank (.clk, .rst_n, .live, .rd_stb, .rd_sel, .wr_stb, .wr_data,
                         .irq_mask, .done, .rd_data, .irq);

  task automatic chk(string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string kind_tag(int i);
    logic [1:0] k = KIND[2*i +: 2];
    return (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
  endfunction

  task automatic step(logic [NB-1:0] lv, logic rd, logic sel, logic wr,
                      logic [NC-1:0] wd, logic [NC-1:0] dn, logic [NB-1:0] msk);
    logic [NB-1:0] nv, nl;
    logic [NC-1:0] nc;
    @(negedge clk);
    live = lv; rd_stb = rd; rd_sel = sel; wr_stb = wr; wr_data = wd; done = dn; irq_mask = msk;
    #1;
    if (sel) chk("R8 control word", rd_data, NB'(mc));
    else for (int i = 0; i < NB; i++) chk(kind_tag(i), NB'(rd_data[i]), NB'(mv[i]));
    chk("R6 irq", NB'(irq), NB'(|(ml & IEN & ~msk)));
    nv = mv; nl = ml; nc = mc;
    for (int i = 0; i < NB; i++) begin
      if (!ml[i] || (rd && !sel)) begin
        logic [1:0] k = KIND[2*i +: 2];
        nv[i] = lv[i];
        nl[i] = (k == 0) ? !lv[i] : (k == 1) ? lv[i] : (lv[i] != mv[i]);
      end
    end
    for (int j = 0; j < NC; j++) begin
      if (wr) begin nc[j] = wd[j]; mcnt[j] = 0; end
      else if (mc[j]) begin
        if (dn[j] || mcnt[j] == TO - 1) begin nc[j] = 0; mcnt[j] = 0; end
        else mcnt[j]++;
      end
    end
    @(posedge clk);
    mv = nv; ml = nl; mc = nc;
  endtask

  task automatic idle(int n, logic sel);
    for (int k = 0; k < n; k++) step(B, 0, sel, 0, '0, '0, '0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin mv[i] = (KIND[2*i +: 2] == 0); ml[i] = 0; end
    mc = '0;
    for (int j = 0; j < NC; j++) mcnt[j] = 0;
    #22;
    chk("R1 status at reset", rd_data, 8'h07);
    chk("R1 irq at reset", NB'(irq), '0);
    rd_sel = 1; #1;
    chk("R1 control at reset", rd_data, '0);
    rd_sel = 0;
    @(negedge clk); rst_n = 1;
    idle(3, 0);

    step(B & ~8'h01, 0, 0, 0, '0, '0, '0);
    idle(3, 0); #2;
    chk("R2 low held", rd_data, 8'h06);
    step(B, 1, 0, 0, '0, '0, '0); #2;
    chk("R5 released", rd_data, 8'h07);

    step(B & ~8'h02, 0, 0, 0, '0, '0, '0);
    step(B, 0, 0, 0, '0, '0, '0); #2;
    chk("R6 irq raised", NB'(irq), 8'h01);
    chk("R2 irq bit held", rd_data, 8'h05);
    step(B, 0, 0, 0, '0, '0, 8'h02); #2;
    chk("R7 masked", NB'(irq), '0);
    step(B & ~8'h02, 1, 0, 0, '0, '0, '0); #2;
    chk("R5 relatch on read", rd_data, 8'h05);
    step(B, 1, 0, 0, '0, '0, '0); #2;
    chk("R5 second read", rd_data, 8'h07);
    chk("R6 irq dropped", NB'(irq), '0);

    step(B | 8'h08, 0, 0, 0, '0, '0, '0);
    step(B, 0, 0, 0, '0, '0, '0); #2;
    chk("R3 high held", rd_data, 8'h0F);
    step(B, 1, 0, 0, '0, '0, '0); #2;
    chk("R3 released", rd_data, 8'h07);

    step(B | 8'h40, 0, 0, 0, '0, '0, '0); #2;
    chk("R4 change captured", rd_data, 8'h47);
    step(B, 0, 0, 0, '0, '0, '0); #2;
    chk("R4 change held", rd_data, 8'h47);
    step(B, 1, 0, 0, '0, '0, '0);
    step(B, 1, 0, 0, '0, '0, '0);

    step(B, 0, 1, 1, 4'b0011, '0, '0); #2;
    chk("R8 write readback", rd_data, 8'h03);
    step(B, 0, 1, 0, '0, 4'b0001, '0); #2;
    chk("R9 done clears", rd_data, 8'h02);
    step(B, 0, 1, 1, 4'b0100, 4'b0100, '0); #2;
    chk("R9 write beats done", rd_data, 8'h04);
    rd_sel = 0; #1;
    chk("R8 write leaves status", rd_data, 8'h07);

    step(B, 0, 1, 1, 4'b0001, '0, '0);
    idle(TO - 1, 1); #2;
    chk("R10 still set", rd_data, 8'h01);
    idle(1, 1); #2;
    chk("R10 timed out", rd_data, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      step(r[7:0] ^ (n[3] ? B : ~B), r[9:8] == 0, r[10], r[14:11] == 0, r[18:15],
           r[22:19] & {4{r[23] & r[24]}}, (n[6]) ? r[31:24] : '0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule